// File: doc/BRIEF.md
# Narrow-Write Lane Replicator

This block sits between a 32-bit bus that issues byte, half-word and word writes and a 32-bit peripheral that ignores the transfer size and always latches a whole word. A narrow write cannot be steered to a single lane with byte strobes in that case. The block therefore copies the narrow value into every lane of the outgoing word and clears the two low address bits, so that the peripheral sees one full-word write at the word address. Word writes pass through with their address and data untouched.

Both sides use a valid/ready handshake. The outgoing request is held in a single register stage. The block accepts a new request in the same cycle that the held word leaves, so it sustains one write per clock. When the downstream side stalls, the held word stays unchanged and the input side is stalled as well. The reset input is asserted asynchronously and released through a two-stage synchronizer. The block accepts nothing until that release has completed.

Top module: `nwr_widen`

## Requirements
- R1: A byte write (size code 2'b00) is emitted with the byte value copied into all four byte lanes: for example, data 0x000000B0 gives 0xB0B0B0B0.
- R2: A byte write to any byte offset (address bits [1:0] = 0, 1, 2 or 3) is emitted with address bits [1:0] cleared and the upper address bits unchanged.
- R3: A half-word write (size code 2'b01) is emitted with the 16-bit value in both half-word lanes: for example, 0xB1B0 gives 0xB1B0B1B0.
- R4: A half-word write to offset 0 or 2 is emitted with address bits [1:0] cleared and the upper address bits unchanged.
- R5: A word write (size code 2'b10) is emitted with address and data exactly as received, including any nonzero low address bits.
- R6: The unused size code 2'b11 is handled exactly like a word write.
- R7: The narrow value always comes from data bits [7:0] (byte) or [15:0] (half-word), whatever the address offset. Any data bits above them have no effect on the emitted word.
- R8: A request accepted on a clock edge (in_valid and in_ready both high) appears on out_valid, out_addr and out_data right after that edge.
- R9: While out_valid is high and out_ready is low, out_valid, out_addr and out_data hold their values and in_ready is low. When out_ready is high, or when no word is held, in_ready is high.
- R10: While rst_n is low, out_valid and in_ready are low. After rst_n rises, in_ready stays low until the second rising clock edge has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Block can take the request this cycle |
| in_addr | input | ADDR_W (32) | Byte address of the write |
| in_size | input | 2 | Size code: 00 byte, 01 half-word, 10 word, 11 treated as word |
| in_data | input | DATA_W (32) | Write data, narrow values in the low lanes |
| out_valid | output | 1 | Full-word write held for the peripheral |
| out_ready | input | 1 | Peripheral takes the held word this cycle |
| out_addr | output | ADDR_W (32) | Word address (low bits cleared for narrow writes) |
| out_data | output | DATA_W (32) | Replicated or passed-through data word |

## Verification
The data and address properties assume that in_size, in_addr and in_data are known values whenever in_valid is high, and that rst_n changes only away from the active clock edge. The properties do not assume that the request is held steady under stall, because each one looks only at the cycle of acceptance. Even so, the stimulus follows the handshake: it changes a request only after that request has been accepted, or while in_valid is low. The address and data values come from a pseudo-random source and are never X. Reset is driven at a point between clock edges.

// File: rtl/nwr_pkg.sv
package nwr_pkg;

  // Incoming transfer size encoding
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } nwr_size_e;

  // Replication mode chosen for the datapath
  typedef enum logic [1:0] {
    REP_BYTE = 2'b00,
    REP_HALF = 2'b01,
    REP_PASS = 2'b10
  } rep_mode_e;

endpackage

// File: rtl/nwr_rst_sync.sv
module nwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/nwr_size_decode.sv
module nwr_size_decode
  import nwr_pkg::*;
(
  input  logic [1:0] size_i,
  output rep_mode_e  mode_o
);

  always_comb begin
    unique case (nwr_size_e'(size_i))
      SZ_BYTE: mode_o = REP_BYTE;
      SZ_HALF: mode_o = REP_HALF;
      SZ_WORD: mode_o = REP_PASS;
      SZ_RSVD: mode_o = REP_PASS;   // unused code follows the word path
      default: mode_o = REP_PASS;
    endcase
  end

endmodule

// File: rtl/nwr_lane_fill.sv
module nwr_lane_fill
  import nwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  rep_mode_e          mode_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  // Per-lane source selection: every lane of a narrow write is fed from the
  // low byte or from the matching byte of the low half-word.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HALF_SEL = g % 2;
    logic [7:0] lane_byte;

    always_comb begin
      unique case (mode_i)
        REP_BYTE: lane_byte = data_i[7:0];
        REP_HALF: lane_byte = data_i[HALF_SEL*8 +: 8];
        default:  lane_byte = data_i[g*8 +: 8];
      endcase
    end

    assign data_o[g*8 +: 8] = lane_byte;
  end

  logic [ADDR_W-1:0] addr_aligned;

  assign addr_aligned = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign addr_o       = (mode_i == REP_PASS) ? addr_i : addr_aligned;

endmodule

// File: rtl/nwr_out_stage.sv
module nwr_out_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic              vld_q,  vld_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              load_en;

  // Next-state logic
  always_comb begin
    in_ready = srst_n && (!vld_q || out_ready);
    load_en  = in_valid && in_ready;
    if (load_en) begin
      vld_d = 1'b1;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end else begin
      vld_d = vld_q;
    end
  end

  // Control register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload registers with explicit clock enable
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= d_addr;
      data_q <= d_data;
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_data  = data_q;

endmodule

// File: rtl/nwr_widen.sv
module nwr_widen
  import nwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic              srst_n;
  rep_mode_e         mode;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;

  nwr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nwr_size_decode u_dec (
    .size_i (in_size),
    .mode_o (mode)
  );

  nwr_lane_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill (
    .mode_i (mode),
    .addr_i (in_addr),
    .data_i (in_data),
    .addr_o (fill_addr),
    .data_o (fill_data)
  );

  nwr_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .srst_n    (srst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_addr    (fill_addr),
    .d_data    (fill_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data)
  );

endmodule

// File: rtl/nwr_widen_chk.sv
module nwr_widen_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_size,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b00 |=> out_data == {LANES{$past(in_data[7:0])}});

  // R2
  byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b00 |=>
      out_addr == {$past(in_addr[ADDR_W-1:OFS_W]), {OFS_W{1'b0}}});

  // R3
  half_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b01 |=> out_data == {(LANES/2){$past(in_data[15:0])}});

  // R4
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b01 |=>
      out_addr == {$past(in_addr[ADDR_W-1:OFS_W]), {OFS_W{1'b0}}});

  // R5
  word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b10 |=>
      out_data == $past(in_data) && out_addr == $past(in_addr));

  // R6
  rsvd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'b11 |=>
      out_data == $past(in_data) && out_addr == $past(in_addr));

  // R8
  load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_data) && $stable(out_addr));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !in_ready);

endmodule

bind nwr_widen nwr_widen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .in_size   (in_size),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data)
);

// File: tb/nwr_widen_tb_top.sv
`timescale 1ns/1ps
module nwr_widen_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [AW-1:0] in_addr;
  logic [1:0]    in_size;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;   // 250 MHz

  nwr_widen #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;

  // ---------------- reference model ----------------
  int            rcnt;
  logic          m_vld;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  string         m_tag;
  logic          m_rdy;

  function automatic logic [DW-1:0] exp_data(logic [1:0] sz, logic [DW-1:0] d);
    logic [DW-1:0] r;
    case (sz)
      2'b00:   r = {d[7:0], d[7:0], d[7:0], d[7:0]};   // R1 R7
      2'b01:   r = {d[15:0], d[15:0]};                 // R3 R7
      default: r = d;                                  // R5 R6
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [1:0] sz, logic [AW-1:0] a);
    return (sz == 2'b00 || sz == 2'b01) ? (a & ~32'h3) : a;   // R2 R4 R5
  endfunction

  function automatic string tag_of(logic [1:0] sz);
    case (sz)
      2'b00:   return "R1 R2 R7";
      2'b01:   return "R3 R4 R7";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  assign m_rdy = (rcnt == 2) && (!m_vld || out_ready);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt  <= 0;
      m_vld <= 1'b0;
    end else begin
      if (rcnt < 2) rcnt <= rcnt + 1;
      if (m_rdy && in_valid) begin
        m_vld  <= 1'b1;
        m_addr <= exp_addr(in_size, in_addr);
        m_data <= exp_data(in_size, in_data);
        m_tag  <= tag_of(in_size);
      end else if (out_ready) begin
        m_vld <= 1'b0;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (in_ready !== m_rdy) begin
        fails++;
        $display("FAIL %s: in_ready=%b expected %b", (rcnt < 2) ? "R10" : "R9",
                 in_ready, m_rdy);
      end
      if (out_valid !== m_vld) begin
        fails++;
        $display("FAIL %s: out_valid=%b expected %b", (rcnt < 2) ? "R10" : "R8",
                 out_valid, m_vld);
      end else if (m_vld && (out_data !== m_data || out_addr !== m_addr)) begin
        fails++;
        $display("FAIL %s R9: out_addr=%h out_data=%h expected %h %h",
                 m_tag, out_addr, out_data, m_addr, m_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(logic [AW-1:0] a, logic [1:0] sz, logic [DW-1:0] d, logic ordy);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = a; in_size = sz; in_data = d; out_ready = ordy;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, cycles=200000 expected fewer");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_size = '0; in_data = '0;
    out_ready = 1'b1;
    // R10: reset state, then two-edge release
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R1 R2 R7: byte at every offset, garbage above the low byte
    for (int o = 0; o < 4; o++) send(32'h4000_1000 + o, 2'b00, 32'hDEAD_BEB0, 1'b1);
    // R3 R4 R7: half-word at both offsets
    send(32'h4000_2000, 2'b01, 32'h1234_B1B0, 1'b1);
    send(32'h4000_2002, 2'b01, 32'hFFFF_B1B0, 1'b1);
    // R5: word passthrough, including odd low address bits
    send(32'h4000_3000, 2'b10, 32'hCAFE_F00D, 1'b1);
    send(32'h4000_3003, 2'b10, 32'h0102_0304, 1'b1);
    // R6: unused size code
    send(32'h4000_4001, 2'b11, 32'h8765_4321, 1'b1);
    idle(2);

    // R9: stall with a held word and a second request waiting
    send(32'h5000_0003, 2'b00, 32'h0000_00A5, 1'b0);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = 32'h5000_0006; in_size = 2'b01; in_data = 32'h0000_7E81;
    repeat (5) @(posedge clk);
    #1 out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    idle(2);

    // Pseudo-random traffic honouring the handshake
    for (int i = 0; i < 3000; i++) begin
      bit stall;
      @(negedge clk);
      stall = in_valid && !in_ready;
      @(posedge clk); #1;
      if (!stall) begin
        in_valid = ($urandom % 4) != 0;
        in_addr  = $urandom;
        in_size  = 2'($urandom % 4);
        in_data  = $urandom;
      end
      out_ready = ($urandom % 3) != 0;
    end

    // R10: reset in the middle of traffic
    @(posedge clk); #1;
    rst_n = 1'b0; in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    idle(2);
    finish_run();
  end

endmodule